// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This unit sits beside a CPU bus controller on a 20-bit address bus. It decodes each bus cycle against two software-loaded control words and drives active-low select lines. The upper-memory select covers a window that always ends at the top of the 1 MB space. The window's lower bound comes from the high byte of the upper control word. Seven peripheral selects each cover one 128-byte slice of a peripheral block. The block starts on a programmable 1 KB boundary and lives in either I/O or memory space.

Each access also receives a wait-state count and a flag that says whether the external ready input is ignored. The unit turns these into a ready output for the bus controller. After reset, the upper window is at its largest size with the slowest timing, so the boot fetch works before any register is written. The peripheral selects stay silent until software loads the peripheral word.

Top module: `csel_unit`

## Requirements
- R1: After reset the upper word reads as 0xE03F: window 0xE0000-0xFFFFF, ready ignored, 3 wait states. No peripheral select is asserted until the peripheral word has been written once.
- R2: With word U in the upper register (reg_sel=0), ucs_n is low for a memory cycle (cyc_mem=1) when cyc_addr[19:12] >= U[15:8]. So 0xFC3C covers 0xFC000-0xFFFFF, 0xF83C covers 0xF8000-, 0xF03C covers 0xF0000- and 0xE03C covers 0xE0000-. I/O cycles never assert ucs_n.
- R3: The peripheral word P (reg_sel=1) holds the block base address bits 19:10 in P[15:6]. pcs_n[k] is low when cyc_addr[19:10] equals P[15:6] and cyc_addr[9:7] equals k, for k from 0 to 6. Offsets 0x380-0x3FF of the block select nothing.
- R4: P[5] selects the space of the peripheral block: 1 for memory cycles, 0 for I/O cycles. A cycle in the other space selects no peripheral.
- R5: At most one select is low at a time. When a peripheral slice and the upper window both match, only the peripheral select is asserted, and the access takes the peripheral word's timing.
- R6: While cyc_valid is low, all selects are high and rdy_out is low.
- R7: The low three bits of the matching word set the timing. Bit 2 = 1 means ext_rdy is ignored, and bits 1:0 give N wait states. rdy_out is then low for exactly N clocks from the first clock of the cycle: 100 gives 0, 101 gives 1, 110 gives 2, 111 gives 3.
- R8: When bit 2 = 0, rdy_out goes high only once N clocks have passed and ext_rdy is high.
- R9: A cycle that matches no select gets 0 wait states and honours ext_rdy.
- R10: A write with reg_we=1 loads reg_wdata into the register chosen by reg_sel. It governs cycles that start on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the upper word, 1 selects the peripheral word |
| reg_wdata | input | 16 | Register write data |
| cyc_valid | input | 1 | Bus cycle in progress (address valid) |
| cyc_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| cyc_addr | input | 20 | Cycle address |
| ext_rdy | input | 1 | External ready from the addressed device |
| ucs_n | output | 1 | Upper-memory select, active low |
| pcs_n | output | 7 | Peripheral selects, active low |
| rdy_out | output | 1 | Ready to the bus controller |

## Verification
On every clock, the assertions check four things. At most one select is active. Selects and ready stay quiet outside a cycle. The upper select never appears on an I/O cycle, and no peripheral select decodes the unused top slice. Any cycle that has lasted three clocks with ext_rdy high must report ready. Only the bench's scenarios can show the exact window bounds for each control-word encoding, and the exact slice chosen for each offset. The same goes for the exact number of ready-low clocks for each field value, the interplay of a late ext_rdy with the wait count, and the disabled peripheral selects after reset.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int ADDR_W_DEF  = 20;
    localparam int CTL_W_DEF   = 16;
    localparam int BLOCK_W_DEF = 10;
    localparam int SLICE_W_DEF = 7;
    localparam int NUM_PCS_DEF = 7;
    localparam int UP_W_DEF    = 8;
    localparam int WAIT_W      = 2;

    // timing field of a control word: bit 2 ignores ready, bits 1:0 wait states
    typedef struct packed {
        logic              ign_rdy;
        logic [WAIT_W-1:0] waits;
    } wcfg_t;

    localparam wcfg_t WCFG_UNSEL = '{ign_rdy: 1'b0, waits: '0};
endpackage

// File: rtl/csel_regs.sv
module csel_regs #(
    parameter int              CTL_W     = 16,
    parameter logic [15:0]     UPPER_RST = 16'hE03F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] upper_o,
    output logic [CTL_W-1:0] per_o,
    output logic             per_on_o
);
    typedef struct packed {
        logic [CTL_W-1:0] upper;
        logic [CTL_W-1:0] per;
        logic             per_on;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            if (reg_sel) begin
                regs_d.per    = reg_wdata;
                regs_d.per_on = 1'b1;
            end else begin
                regs_d.upper  = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.upper  <= CTL_W'(UPPER_RST);
            regs_q.per    <= '0;
            regs_q.per_on <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign upper_o  = regs_q.upper;
    assign per_o    = regs_q.per;
    assign per_on_o = regs_q.per_on;
endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int CTL_W   = 16,
    parameter int BLOCK_W = 10,
    parameter int SLICE_W = 7,
    parameter int NUM_PCS = 7,
    parameter int UP_W    = 8
) (
    input  logic               valid_i,
    input  logic               mem_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CTL_W-1:0]   upper_i,
    input  logic [CTL_W-1:0]   per_i,
    input  logic               per_on_i,
    output logic               ucs_n_o,
    output logic [NUM_PCS-1:0] pcs_n_o,
    output wcfg_t              cfg_o
);
    localparam int BASE_W = ADDR_W - BLOCK_W;
    localparam int IDX_W  = BLOCK_W - SLICE_W;
    localparam int SPACE_BIT = CTL_W - BASE_W - 1;
    localparam int CFG_W  = $bits(wcfg_t);

    logic               up_hit;
    logic               blk_hit;
    logic [IDX_W-1:0]   slice;
    logic [NUM_PCS-1:0] pcs_hit;
    logic               any_pcs;

    // window runs from the programmed lower bound up to the top of the space
    assign up_hit  = mem_i && (addr_i[ADDR_W-1 -: UP_W] >= upper_i[CTL_W-1 -: UP_W]);
    assign blk_hit = per_on_i && (mem_i == per_i[SPACE_BIT])
                     && (addr_i[ADDR_W-1 -: BASE_W] == per_i[CTL_W-1 -: BASE_W]);
    assign slice   = addr_i[BLOCK_W-1:SLICE_W];

    for (genvar k = 0; k < NUM_PCS; k++) begin : g_slice
        assign pcs_hit[k] = blk_hit && (slice == IDX_W'(k));
    end

    assign any_pcs = |pcs_hit;
    assign ucs_n_o = !(valid_i && up_hit && !any_pcs);
    assign pcs_n_o = ~(pcs_hit & {NUM_PCS{valid_i}});

    always_comb begin
        if (any_pcs)     cfg_o = wcfg_t'(per_i[CFG_W-1:0]);
        else if (up_hit) cfg_o = wcfg_t'(upper_i[CFG_W-1:0]);
        else             cfg_o = WCFG_UNSEL;
    end
endmodule

// File: rtl/csel_wait.sv
module csel_wait
    import csel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid_i,
    input  wcfg_t cfg_i,
    input  logic  ext_rdy_i,
    output logic  rdy_o
);
    typedef struct packed {
        logic              active;
        logic [WAIT_W-1:0] cnt;
    } wst_t;

    wst_t wst_d, wst_q;
    logic [WAIT_W-1:0] cnt_eff;

    always_comb begin
        // first clock of a cycle loads the count straight from the decode
        cnt_eff      = wst_q.active ? wst_q.cnt : cfg_i.waits;
        rdy_o        = valid_i && (cnt_eff == '0) && (cfg_i.ign_rdy || ext_rdy_i);
        wst_d.active = valid_i;
        if (!valid_i || cnt_eff == '0) wst_d.cnt = '0;
        else                           wst_d.cnt = cnt_eff - WAIT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wst_q <= '0;
        else        wst_q <= wst_d;
    end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int CTL_W   = CTL_W_DEF,
    parameter int BLOCK_W = BLOCK_W_DEF,
    parameter int SLICE_W = SLICE_W_DEF,
    parameter int NUM_PCS = NUM_PCS_DEF,
    parameter int UP_W    = UP_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [CTL_W-1:0]   reg_wdata,
    input  logic               cyc_valid,
    input  logic               cyc_mem,
    input  logic [ADDR_W-1:0]  cyc_addr,
    input  logic               ext_rdy,
    output logic               ucs_n,
    output logic [NUM_PCS-1:0] pcs_n,
    output logic               rdy_out
);
    logic [CTL_W-1:0] upper_w;
    logic [CTL_W-1:0] per_w;
    logic             per_on;
    wcfg_t            cfg;

    csel_regs #(.CTL_W(CTL_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .upper_o  (upper_w),
        .per_o    (per_w),
        .per_on_o (per_on)
    );

    csel_decode #(
        .ADDR_W (ADDR_W),
        .CTL_W  (CTL_W),
        .BLOCK_W(BLOCK_W),
        .SLICE_W(SLICE_W),
        .NUM_PCS(NUM_PCS),
        .UP_W   (UP_W)
    ) i_decode (
        .valid_i (cyc_valid),
        .mem_i   (cyc_mem),
        .addr_i  (cyc_addr),
        .upper_i (upper_w),
        .per_i   (per_w),
        .per_on_i(per_on),
        .ucs_n_o (ucs_n),
        .pcs_n_o (pcs_n),
        .cfg_o   (cfg)
    );

    csel_wait i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (cyc_valid),
        .cfg_i    (cfg),
        .ext_rdy_i(ext_rdy),
        .rdy_o    (rdy_out)
    );
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
    parameter int ADDR_W  = 20,
    parameter int BLOCK_W = 10,
    parameter int SLICE_W = 7,
    parameter int NUM_PCS = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_valid,
    input logic               cyc_mem,
    input logic [ADDR_W-1:0]  cyc_addr,
    input logic               ext_rdy,
    input logic               ucs_n,
    input logic [NUM_PCS-1:0] pcs_n,
    input logic               rdy_out
);
    logic [1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            len_q <= '0;
        else if (!cyc_valid)   len_q <= '0;
        else if (len_q != 2'd3) len_q <= len_q + 2'd1;
    end

    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ucs_n, ~pcs_n}));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> (ucs_n && (&pcs_n) && !rdy_out));

    a_r2_upper_memory_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ucs_n |-> cyc_mem);

    a_r3_no_top_slice: assert property (@(posedge clk) disable iff (!rst_n)
        !(&pcs_n) |-> (int'(cyc_addr[BLOCK_W-1:SLICE_W]) < NUM_PCS));

    // R7, R8: no field can hold a cycle longer than three clocks once ext_rdy is high
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && len_q == 2'd3 && ext_rdy) |-> rdy_out);
endmodule

bind csel_unit csel_unit_chk #(
    .ADDR_W (ADDR_W),
    .BLOCK_W(BLOCK_W),
    .SLICE_W(SLICE_W),
    .NUM_PCS(NUM_PCS)
) i_chk (.*);

// File: tb/test_csel_unit.sv
`timescale 1ns/1ps
module test_csel_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        cyc_valid = 1'b0;
    logic        cyc_mem = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        ucs_n;
    logic [6:0]  pcs_n;
    logic        rdy_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    csel_unit i_csel_unit (.*);

    typedef struct packed {
        logic [15:0] up;
        logic [15:0] per;
        logic        mem;
        logic [19:0] addr;
        logic        ucs;
        logic [6:0]  pcs;
        logic [1:0]  low;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{16'hFC3C, 16'h0804, 1'b1, 20'hFC000, 1'b0, 7'h7F, 2'd0},
        '{16'hFC3C, 16'h0804, 1'b1, 20'hFBFFF, 1'b1, 7'h7F, 2'd0},
        '{16'hF83C, 16'h0804, 1'b1, 20'hF8000, 1'b0, 7'h7F, 2'd0},
        '{16'hF83D, 16'h0804, 1'b1, 20'hF7FFF, 1'b1, 7'h7F, 2'd0},
        '{16'hF03E, 16'h0804, 1'b1, 20'hF0000, 1'b0, 7'h7F, 2'd2},
        '{16'hF03C, 16'h0804, 1'b1, 20'hEFFFF, 1'b1, 7'h7F, 2'd0},
        '{16'hE03F, 16'h0804, 1'b1, 20'hE0000, 1'b0, 7'h7F, 2'd3},
        '{16'hE03F, 16'h0804, 1'b1, 20'hDFFFF, 1'b1, 7'h7F, 2'd0},
        '{16'hE03C, 16'h0804, 1'b0, 20'hE0000, 1'b1, 7'h7F, 2'd0},
        '{16'hE03C, 16'h0804, 1'b0, 20'h08000, 1'b1, 7'h7E, 2'd0},
        '{16'hE03C, 16'h0805, 1'b0, 20'h0837F, 1'b1, 7'h3F, 2'd1},
        '{16'hE03C, 16'h0806, 1'b0, 20'h08380, 1'b1, 7'h7F, 2'd0},
        '{16'hE03C, 16'h0807, 1'b0, 20'h08100, 1'b1, 7'h7B, 2'd3},
        '{16'hE03C, 16'h0804, 1'b1, 20'h08000, 1'b1, 7'h7F, 2'd0},
        '{16'hE03F, 16'hF825, 1'b1, 20'hF8080, 1'b1, 7'h7D, 2'd1},
        '{16'hE03F, 16'hF825, 1'b1, 20'hF8400, 1'b0, 7'h7F, 2'd3},
        '{16'hE03C, 16'h0804, 1'b0, 20'h083FF, 1'b1, 7'h7F, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // one bus cycle; ext_rdy rises after extd clocks; counts ready-low clocks
    task automatic run_cyc(input logic mem, input logic [19:0] a, input int extd,
                           output logic ucs, output logic [6:0] pcs, output int low);
        @(negedge clk);
        cyc_mem = mem; cyc_addr = a; cyc_valid = 1'b1; ext_rdy = (extd == 0);
        #0.5;
        ucs = ucs_n; pcs = pcs_n; low = 0;
        while (!rdy_out && low < 20) begin
            low++;
            @(negedge clk);
            ext_rdy = (low >= extd);
            #0.5;
        end
        @(negedge clk);
        cyc_valid = 1'b0; ext_rdy = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic u;
        logic [6:0] p;
        int l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        // R6: quiet while idle
        chk("R6 idle ucs_n", ucs_n, 1);
        chk("R6 idle pcs_n", pcs_n, 7'h7F);
        chk("R6 idle rdy_out", rdy_out, 0);
        // R1: reset window and timing
        run_cyc(1'b1, 20'hE0000, 0, u, p, l);
        chk("R1 reset window ucs_n", u, 0);
        chk("R1 reset wait count", l, 3);
        run_cyc(1'b1, 20'hDFFFF, 0, u, p, l);
        chk("R1 below reset window", u, 1);
        // R1: peripheral selects off before first write (base 0, I/O)
        run_cyc(1'b0, 20'h00000, 0, u, p, l);
        chk("R1 pcs disabled", p, 7'h7F);
        chk("R1 R9 unselected waits", l, 0);

        // table: R2 R3 R4 R5 R7 R10
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, TBL[i].up);
            wr(1'b1, TBL[i].per);
            run_cyc(TBL[i].mem, TBL[i].addr, 0, u, p, l);
            chk($sformatf("R2 R4 R5 R10 vec %0d ucs_n", i), u, TBL[i].ucs);
            chk($sformatf("R3 R4 R5 vec %0d pcs_n", i), p, TBL[i].pcs);
            chk($sformatf("R7 vec %0d ready-low clocks", i), l, TBL[i].low);
        end

        // R8: honour ready, 0 waits, late ready
        wr(1'b0, 16'hE038);
        run_cyc(1'b1, 20'hE1234, 2, u, p, l);
        chk("R8 no waits late ready", l, 2);
        wr(1'b0, 16'hE039);
        run_cyc(1'b1, 20'hE1234, 0, u, p, l);
        chk("R8 one wait ready early", l, 1);
        run_cyc(1'b1, 20'hE1234, 3, u, p, l);
        chk("R8 one wait ready late", l, 3);
        // R7: ignore a ready that never comes
        wr(1'b0, 16'hE03E);
        run_cyc(1'b1, 20'hFFFFF, 50, u, p, l);
        chk("R7 ready ignored", l, 2);
        // R9: unselected honours ready
        run_cyc(1'b1, 20'h12345, 2, u, p, l);
        chk("R9 unselected late ready", l, 2);
        chk("R9 unselected no select", {u, p}, 8'hFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule